// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block gives a host processor indirect access to device configuration space through two small register ports. The host first writes a 32-bit selector into the address port. The selector names a bus, a device/function and a register offset, and its top bit opens a data window. Accesses to the data port are then turned into single requests on a downstream configuration interface, and the response is handed back to the host.

The bridge decides whether an access may reach a target at all. It refuses accesses when the window is closed, when no device answers at the selected bus/devfn, when a hot-added function is hidden because its function 0 is missing, when the length is not 1, 2 or 4 bytes, or when the offset lies at or above the configuration limit. A refused read returns all ones in the same cycle and a refused write has no effect. A forwarded access keeps the host stalled until the target acknowledges it. Its length is trimmed so that it never runs past the limit.

Top module: `cfg_window_bridge`

## Requirements
- R1: After reset the selector reads 0, so a data-port read returns 0xFFFFFFFF and raises no downstream request.
- R2: The selector is loaded only by a host write to the address port (`h_sel`=0) with `h_addr`=0 and `h_len`=4. Any other write leaves it unchanged.
- R3: A read of the address port returns the full 32-bit selector whatever `h_len` is, and completes in the cycle it is presented.
- R4: While selector bit 31 is 0, data-port reads return 0xFFFFFFFF and data-port writes issue no downstream request.
- R5: The downstream bus is selector bits 23:16 and the devfn is bits 15:8. The offset is (selector OR `h_addr`) masked to the configuration space size (`SPACE`).
- R6: If `d_present` is low for the selected bus/devfn, reads return all ones and writes issue no request.
- R7: If `d_hotadd` is high, devfn bits 2:0 are nonzero and `d_fn0_present` is low, the function is hidden: reads return all ones and writes issue no request.
- R8: An access whose offset is at or above `LIMIT` is refused (all ones, or no request). Otherwise `d_len` is the smaller of `h_len` and `LIMIT` minus the offset.
- R9: An `h_len` other than 1, 2 or 4 is refused, in the same way as R8.
- R10: A forwarded access holds `d_req` and all request fields steady until `d_ack`. `h_ready` stays low until the cycle of `d_ack`, and refused accesses complete with no wait.
- R11: Read data is `d_rdata` with the bytes above the trimmed length forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| h_req | input | 1 | Host access request, held until `h_ready` |
| h_we | input | 1 | Host write (1) or read (0) |
| h_sel | input | 1 | 0 = address port, 1 = data port |
| h_addr | input | 2 | Byte address within the port |
| h_len | input | 3 | Access length in bytes |
| h_wdata | input | 32 | Host write data |
| h_ready | output | 1 | Access completes this cycle |
| h_rdata | output | 32 | Read data, valid with `h_ready` |
| d_req | output | 1 | Downstream request, held until `d_ack` |
| d_we | output | 1 | Downstream write flag |
| d_bus | output | 8 | Target bus number |
| d_devfn | output | 8 | Target device/function |
| d_off | output | OFFW | Register offset |
| d_len | output | 3 | Trimmed length in bytes |
| d_wdata | output | 32 | Downstream write data |
| d_ack | input | 1 | Downstream response handshake |
| d_rdata | input | 32 | Downstream read data |
| d_present | input | 1 | A device answers at `d_bus`/`d_devfn` |
| d_hotadd | input | 1 | The selected device was hot-added |
| d_fn0_present | input | 1 | Function 0 of the selected device exists |

## Verification
A corrupted selector shows up on the first later address-port read. It also shows up on the first data access, as a wrong bus, devfn or offset on the request, or as all ones where data was expected. A wrong offset or trimmed length is visible on `d_off`/`d_len` from the cycle the request is accepted. A lost or early release of the busy state shows within the same access: `h_ready` rises before `d_ack`, or the request fields move while the request is still waiting.

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge #(
  parameter int SPACE = 256,
  parameter int LIMIT = 256,
  localparam int OFFW = $clog2(SPACE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            h_req,
  input  logic            h_we,
  input  logic            h_sel,
  input  logic [1:0]      h_addr,
  input  logic [2:0]      h_len,
  input  logic [31:0]     h_wdata,
  output logic            h_ready,
  output logic [31:0]     h_rdata,
  output logic            d_req,
  output logic            d_we,
  output logic [7:0]      d_bus,
  output logic [7:0]      d_devfn,
  output logic [OFFW-1:0] d_off,
  output logic [2:0]      d_len,
  output logic [31:0]     d_wdata,
  input  logic            d_ack,
  input  logic [31:0]     d_rdata,
  input  logic            d_present,
  input  logic            d_hotadd,
  input  logic            d_fn0_present
);
  logic [31:0]     cfg_q;
  logic            busy_q;
  logic [OFFW-1:0] off_q;
  logic [2:0]      len_q;
  logic            we_q;
  logic [31:0]     wd_q;

  wire [OFFW-1:0] off    = OFFW'({cfg_q[31:2], cfg_q[1:0] | h_addr});
  wire            in_rng = {1'b0, off} < (OFFW+1)'(LIMIT);
  wire [OFFW:0]   room   = (OFFW+1)'(LIMIT) - {1'b0, off};
  wire            len_ok = (h_len == 3'd1) || (h_len == 3'd2) || (h_len == 3'd4);
  wire            hidden = d_hotadd && (d_devfn[2:0] != 3'd0) && !d_fn0_present;
  wire            go     = h_sel && cfg_q[31] && in_rng && len_ok && d_present && !hidden;
  wire [2:0]      clip   = ((OFFW+1)'(h_len) < room) ? h_len : room[2:0];
  wire            accept = h_req && !busy_q && go;
  wire            ld_cfg = h_req && !busy_q && h_we && !h_sel && (h_addr == 2'd0) && (h_len == 3'd4);

  logic [31:0] rmask;
  always_comb
    case (len_q)
      3'd1:    rmask = 32'h0000_00FF;
      3'd2:    rmask = 32'h0000_FFFF;
      3'd3:    rmask = 32'h00FF_FFFF;
      default: rmask = 32'hFFFF_FFFF;
    endcase

  assign h_ready = busy_q ? d_ack : (h_req && !go);
  assign h_rdata = busy_q ? (d_rdata & rmask) : (h_sel ? 32'hFFFF_FFFF : cfg_q);

  assign d_req   = busy_q;
  assign d_we    = we_q;
  assign d_bus   = cfg_q[23:16];
  assign d_devfn = cfg_q[15:8];
  assign d_off   = off_q;
  assign d_len   = len_q;
  assign d_wdata = wd_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_q  <= '0;
      busy_q <= 1'b0;
      off_q  <= '0;
      len_q  <= '0;
      we_q   <= 1'b0;
      wd_q   <= '0;
    end else if (!busy_q) begin
      if (ld_cfg) cfg_q <= h_wdata;
      if (accept) begin
        busy_q <= 1'b1;
        off_q  <= off;
        len_q  <= clip;
        we_q   <= h_we;
        wd_q   <= h_wdata;
      end
    end else if (d_ack) begin
      busy_q <= 1'b0;
    end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    d_req && !d_ack |=> d_req && $stable(d_off) && $stable(d_len) && $stable(d_we) && $stable(d_wdata));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    d_req && !d_ack |-> !h_ready);

  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    d_req |-> cfg_q[31]);

  p_clip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    d_req |-> (d_len != 3'd0) && (d_len <= 3'd4) && ({1'b0, d_off} + (OFFW+1)'(d_len) <= (OFFW+1)'(LIMIT)));

  p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(h_req && h_we && !h_sel && h_addr == 2'd0 && h_len == 3'd4));
endmodule

// File: tb/tb_cfg_window_bridge.sv
module tb_cfg_window_bridge;
  localparam int SPACE = 256;
  localparam int LIMIT = 240;

  logic clk = 0, rst_n = 0;
  logic h_req = 0, h_we = 0, h_sel = 0;
  logic [1:0] h_addr = 0;
  logic [2:0] h_len = 0;
  logic [31:0] h_wdata = 0;
  logic h_ready;
  logic [31:0] h_rdata;
  logic d_req, d_we;
  logic [7:0] d_bus, d_devfn, d_off;
  logic [2:0] d_len;
  logic [31:0] d_wdata;
  logic d_ack = 0;
  logic [31:0] d_rdata = 0;
  logic d_present, d_hotadd, d_fn0_present;

  cfg_window_bridge #(.SPACE(SPACE), .LIMIT(LIMIT)) dut (.*);

  always #10 clk = ~clk;

  assign d_present     = (d_devfn[7:3] < 5'd4) && !(d_devfn[7:3] == 5'd3 && d_devfn[2:0] == 3'd0);
  assign d_hotadd      = d_devfn[7:3] >= 5'd2;
  assign d_fn0_present = d_devfn[7:3] != 5'd3;

  int n_chk = 0, n_fail = 0, n_req = 0, cyc = 0;
  logic [7:0] l_bus, l_devfn, l_off;
  logic [2:0] l_len;
  logic l_we;
  logic [31:0] l_wd;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [7:0] bus, input logic [7:0] dfn, input logic [7:0] o);
    return {o + 8'd3, o + 8'd2, o + 8'd1, o} ^ {4{dfn}} ^ {bus, 8'h00, bus, 8'h00};
  endfunction

  always @(posedge clk) cyc++;

  initial begin : responder
    int cnt = 0;
    logic [7:0] f_off;
    logic [2:0] f_len;
    logic [31:0] f_wd;
    forever begin
      @(negedge clk);
      d_ack = 0;
      if (d_req) begin
        cnt++;
        if (cnt == 1) begin
          f_off = d_off; f_len = d_len; f_wd = d_wdata;
        end else begin
          chk(d_off == f_off && d_len == f_len && d_wdata == f_wd, "R10 fields held",
              {21'd0, d_len, d_off}, {21'd0, f_len, f_off});
        end
        if (cnt == 3) begin
          d_rdata = model(d_bus, d_devfn, d_off);
          l_bus = d_bus; l_devfn = d_devfn; l_off = d_off; l_len = d_len; l_we = d_we; l_wd = d_wdata;
          n_req++;
          d_ack = 1;
          cnt = 0;
        end
      end
    end
  end

  task automatic acc(input logic sel, input logic we, input logic [1:0] a, input logic [2:0] l,
                     input logic [31:0] wd, output logic [31:0] rd, output int waits);
    @(negedge clk);
    h_req = 1; h_sel = sel; h_we = we; h_addr = a; h_len = l; h_wdata = wd;
    waits = 0;
    #1;
    while (!h_ready) begin
      @(negedge clk); #1;
      waits++;
    end
    rd = h_rdata;
    @(posedge clk); #1;
    h_req = 0;
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] rd, sel;
    int w, nr0;
    logic [7:0] bases [6] = '{8'h00, 8'h10, 8'hEC, 8'hEE, 8'hF0, 8'hFC};
    logic [7:0] dfns  [6] = '{8'h00, 8'h0A, 8'h11, 8'h19, 8'h18, 8'h28};
    repeat (3) @(posedge clk);
    rst_n = 1;

    acc(0, 0, 0, 4, 0, rd, w);
    chk(rd == 0, "R1 selector after reset", rd, 0);
    nr0 = n_req;
    acc(1, 0, 0, 4, 0, rd, w);
    chk(rd == 32'hFFFF_FFFF && n_req == nr0, "R1 data read after reset", rd, 32'hFFFF_FFFF);

    acc(0, 1, 0, 4, 32'h8012_3404, rd, w);
    acc(0, 1, 0, 2, 32'h1111_1111, rd, w);
    acc(0, 0, 0, 4, 0, rd, w);
    chk(rd == 32'h8012_3404, "R2 halfword write ignored", rd, 32'h8012_3404);
    acc(0, 1, 1, 4, 32'h2222_2222, rd, w);
    acc(0, 0, 0, 4, 0, rd, w);
    chk(rd == 32'h8012_3404, "R2 offset write ignored", rd, 32'h8012_3404);
    for (int l = 1; l <= 4; l++) begin
      acc(0, 0, 2'(l - 1), 3'(l), 0, rd, w);
      chk(rd == 32'h8012_3404 && w == 0, "R3 full selector read", rd, 32'h8012_3404);
    end

    for (int en = 0; en < 2; en++)
      foreach (bases[bi])
        foreach (dfns[di]) begin
          logic [7:0] bus;
          bus = 8'h40 + 8'(bi * 7 + di);
          sel = {en[0], 7'h0, bus, dfns[di], bases[bi]};
          acc(0, 1, 0, 4, sel, rd, w);
          for (int a = 0; a < 4; a++)
            for (int l = 0; l < 6; l++) begin
              logic [7:0] o;
              logic dev_ok, hid, rej;
              int room, cl;
              logic [31:0] exp, msk;
              string tag;
              o = bases[bi] | 8'(a);
              dev_ok = (dfns[di][7:3] < 4) && !(dfns[di][7:3] == 3 && dfns[di][2:0] == 0);
              hid = (dfns[di][7:3] >= 2) && (dfns[di][2:0] != 0) && (dfns[di][7:3] == 3);
              rej = 1'b0; tag = "R5 R11 forwarded read";
              if (!(l == 1 || l == 2 || l == 4)) begin rej = 1; tag = "R9 bad length"; end
              if (o >= LIMIT) begin rej = 1; tag = "R8 offset over limit"; end
              if (hid) begin rej = 1; tag = "R7 hidden function"; end
              if (!dev_ok) begin rej = 1; tag = "R6 absent device"; end
              if (!en[0]) begin rej = 1; tag = "R4 window closed"; end
              room = LIMIT - int'(o);
              cl = (l < room) ? l : room;
              msk = (cl >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * cl)) - 1);
              exp = rej ? 32'hFFFF_FFFF : (model(bus, dfns[di], o) & msk);
              nr0 = n_req;
              acc(1, 0, 2'(a), 3'(l), 0, rd, w);
              chk(rd == exp, tag, rd, exp);
              chk(w == (rej ? 0 : 3), "R10 read wait", w, rej ? 0 : 3);
              if (!rej)
                chk(l_bus == bus && l_devfn == dfns[di] && l_off == o && l_len == 3'(cl) && !l_we,
                    "R5 R8 read request fields", {l_bus, l_devfn, l_off, 5'd0, l_len},
                    {bus, dfns[di], o, 5'd0, 3'(cl)});
              else
                chk(n_req == nr0, {tag, " no read request"}, n_req, nr0);
              nr0 = n_req;
              acc(1, 1, 2'(a), 3'(l), {o, bus, dfns[di], 8'hA5}, rd, w);
              chk(n_req == nr0 + (rej ? 0 : 1), {tag, " write"}, n_req, nr0 + (rej ? 0 : 1));
              chk(w == (rej ? 0 : 3), "R10 write wait", w, rej ? 0 : 3);
              if (!rej)
                chk(l_we && l_off == o && l_len == 3'(cl) && l_wd == {o, bus, dfns[di], 8'hA5},
                    "R8 write request", l_wd, {o, bus, dfns[di], 8'hA5});
            end
          acc(0, 0, 0, 4, 0, rd, w);
          chk(rd == sel, "R2 R3 selector kept over data accesses", rd, sel);
        end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule